// File: doc/BRIEF.md
# Oscillator Start-Up Sequencer

This block decides when an oscillator should be powered and reports when its output can be trusted. It runs entirely on a slow, always-on clock of roughly 32 kHz. When the enable is high the block drives an oscillator-run output. If demand-driven mode is selected, the run output is high only while a peripheral is also asking for the clock. Each time the run output rises, a counter measures a settling window of 2^N slow-clock cycles, where N is a 4-bit select. At the end of that window the clock-ready status rises, and one cycle later a permission output for failure detection follows.

The start-up select and the demand-mode flag are copied into internal state only in cycles where the enable is low. While the block is enabled they are frozen. Select 0 gives a 1-cycle wait (about 31 µs at 32 kHz). Select 15 gives 32768 cycles (about 1 s). The reset value of the held select is 13, which gives 8192 cycles (about 250 ms). The analog oscillator and any gain search live outside this block.

Top module: `osc_startup_seq`

## Requirements
- R1: While reset is held, osc_run_o, clk_ready_o and fd_allow_o are all 0.
- R2: With the held demand flag at 0, osc_run_o is 1 in the cycle after en_i is 1, whatever clk_req_i is. It is 0 in the cycle after en_i is 0.
- R3: With the held demand flag at 1, osc_run_o is 1 in the cycle after a cycle where both en_i and clk_req_i are 1. It is 0 in the cycle after either of them is 0.
- R4: clk_ready_o rises exactly 2^S slow-clock edges after the edge that raised osc_run_o, where S is the held 4-bit select. S=0 gives 1 edge, S=3 gives 8, and S=15 gives 32768.
- R5: clk_ready_o is never 1 while osc_run_o is 0, and it falls on the same edge as osc_run_o.
- R6: Every new run period restarts the wait from zero. A run period that is cut short earns no credit toward the next one.
- R7: startup_sel_i and on_demand_i are copied on each edge where en_i is 0. Changes to them while en_i is 1 have no effect on the current run.
- R8: fd_allow_o stays 0 until clk_ready_o has been 1 for one edge. It then follows one edge behind clk_ready_o, and it falls on the same edge as osc_run_o.
- R9: The wait counter saturates at its terminal count. clk_ready_o stays 1 for as long as the run lasts.
- R10: The held select resets to 13 and the held demand flag resets to 0. If en_i is already 1 when reset is released, the first run waits 8192 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Oscillator enable |
| startup_sel_i | input | 4 | Start-up wait exponent (wait = 2^value cycles) |
| on_demand_i | input | 1 | 1: run only while a peripheral requests the clock |
| clk_req_i | input | 1 | Peripheral clock request |
| osc_run_o | output | 1 | Oscillator power/run command |
| clk_ready_o | output | 1 | Start-up wait complete, clock usable |
| fd_allow_o | output | 1 | Failure detection may be armed |

## Verification
The wait length is measured for several selects: 0, 1, 3, 5 and 8, the extreme 15, and the reset default 13. An off-by-one in the count or a wrong exponent therefore gives a different cycle count for each select. Demand mode is driven with the request held low, with the request raised, with the request dropped after ready, and with the request dropped partway through the wait. This separates gating by request from gating by enable, and a restarted count from a resumed one. Select and mode are changed while enabled, which shows whether the frozen copy is really frozen. A long hold after ready shows whether the counter saturates or wraps.

// File: rtl/osc_su_pkg.sv
package osc_su_pkg;

   // Terminal-detect variant used by the wait timer
   typedef enum logic [0:0] {
      SU_DEC_CMP = 1'b0,   // compare counter against shifted one
      SU_DEC_BIT = 1'b1    // test the single counter bit selected by the exponent
   } su_dec_e;

   // Number of slow-clock cycles for a given exponent
   function automatic int unsigned su_cycles(input int unsigned sel);
      return 32'd1 << sel;
   endfunction

endpackage

// File: rtl/osc_su_cfg.sv
module osc_su_cfg #(
   parameter int unsigned          SEL_W   = 4,
   parameter logic [SEL_W-1:0]     RST_SEL = 'hD
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             od_i,
   output logic [SEL_W-1:0] sel_q_o,
   output logic             od_q_o
);

   logic [SEL_W-1:0] sel_q;
   logic             od_q;

   // Settings track the inputs only while disabled
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= RST_SEL;
         od_q  <= 1'b0;
      end else if (!en_i) begin
         sel_q <= sel_i;
         od_q  <= od_i;
      end
   end

   assign sel_q_o = sel_q;
   assign od_q_o  = od_q;

endmodule

// File: rtl/osc_su_run.sv
module osc_su_run (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic od_i,
   input  logic req_i,
   output logic run_d_o,
   output logic run_q_o
);

   logic run_d;
   logic run_q;

   always_comb begin
      run_d = en_i & (~od_i | req_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b0;
      else         run_q <= run_d;
   end

   assign run_d_o = run_d;
   assign run_q_o = run_q;

endmodule

// File: rtl/osc_su_timer.sv
module osc_su_timer
   import osc_su_pkg::*;
#(
   parameter int unsigned SEL_W = 4,
   parameter int unsigned CNT_W = 16,
   parameter su_dec_e     DEC   = SU_DEC_CMP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             run_next_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             ready_o,
   output logic             fd_allow_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             hit;
   logic             fd_q;

   generate
      if (DEC == SU_DEC_CMP) begin : g_dec_cmp
         logic [CNT_W-1:0] term;
         always_comb term = CNT_ONE << sel_i;
         assign hit = (cnt_q == term);
      end else begin : g_dec_bit
         // Counter stops at 2^sel, so that bit alone marks the end
         assign hit = cnt_q[sel_i];
      end
   endgenerate

   // Counts edges of an active run, holding at the terminal count
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (!hit)    cnt_q <= cnt_q + CNT_ONE;
   end

   assign ready_o = run_i & hit;

   // Detection permission trails ready by one edge and drops with run
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fd_q <= 1'b0;
      else         fd_q <= ready_o & run_next_i;
   end

   assign fd_allow_o = fd_q;

endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
   import osc_su_pkg::*;
#(
   parameter int unsigned      SEL_W   = 4,
   parameter int unsigned      CNT_W   = 16,
   parameter logic [SEL_W-1:0] RST_SEL = 'hD,
   parameter su_dec_e          DEC     = SU_DEC_CMP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [SEL_W-1:0] startup_sel_i,
   input  logic             on_demand_i,
   input  logic             clk_req_i,
   output logic             osc_run_o,
   output logic             clk_ready_o,
   output logic             fd_allow_o
);

   localparam int unsigned MAX_EXP = (1 << SEL_W) - 1;

   generate
      if (CNT_W <= MAX_EXP) begin : g_bad_cnt
         $error("CNT_W must exceed the largest start-up exponent");
      end
      if (CNT_W > 32) begin : g_bad_wide
         $error("CNT_W above 32 is not supported");
      end
   endgenerate

   logic [SEL_W-1:0] cfg_sel_q;
   logic             cfg_od_q;
   logic             run_d;
   logic             run_q;

   osc_su_cfg #(.SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .sel_i   (startup_sel_i),
      .od_i    (on_demand_i),
      .sel_q_o (cfg_sel_q),
      .od_q_o  (cfg_od_q)
   );

   osc_su_run u_run (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .od_i    (cfg_od_q),
      .req_i   (clk_req_i),
      .run_d_o (run_d),
      .run_q_o (run_q)
   );

   osc_su_timer #(.SEL_W(SEL_W), .CNT_W(CNT_W), .DEC(DEC)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q),
      .run_next_i (run_d),
      .sel_i      (cfg_sel_q),
      .ready_o    (clk_ready_o),
      .fd_allow_o (fd_allow_o)
   );

   assign osc_run_o = run_q;

endmodule

// File: rtl/osc_startup_seq_chk.sv
module osc_startup_seq_chk #(
   parameter int unsigned SEL_W = 4,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             clk_req_i,
   input logic             osc_run_o,
   input logic             clk_ready_o,
   input logic             fd_allow_o,
   input logic [SEL_W-1:0] cfg_sel,
   input logic             cfg_od
);

   localparam int unsigned LW = CNT_W + 1;

   logic [LW-1:0] run_len;
   logic [LW-1:0] expect_len;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              run_len <= '0;
      else if (!osc_run_o)      run_len <= '0;
      else if (run_len != '1)   run_len <= run_len + LW'(1);
   end

   always_comb expect_len = LW'(1) << cfg_sel;

   // R2
   od_off_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !cfg_od) |=> osc_run_o);

   // R3
   od_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_od && !clk_req_i) |=> !osc_run_o);

   // R2
   disabled_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !osc_run_o);

   // R4
   wait_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_ready_o) |-> (run_len == expect_len));

   // R5
   ready_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_ready_o |-> osc_run_o);

   // R6
   fresh_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(osc_run_o) |-> !clk_ready_o);

   // R7
   cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i)) |-> ($stable(cfg_sel) && $stable(cfg_od)));

   // R8
   fd_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fd_allow_o) |-> $past(clk_ready_o));

   // R8
   fd_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fd_allow_o |-> (osc_run_o && clk_ready_o));

endmodule

bind osc_startup_seq osc_startup_seq_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .en_i        (en_i),
   .clk_req_i   (clk_req_i),
   .osc_run_o   (osc_run_o),
   .clk_ready_o (clk_ready_o),
   .fd_allow_o  (fd_allow_o),
   .cfg_sel     (cfg_sel_q),
   .cfg_od      (cfg_od_q)
);

// File: tb/sim_osc_startup_seq.sv
module sim_osc_startup_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [3:0] sel = 4'd0;
   logic       od = 1'b0;
   logic       req = 1'b0;
   logic       run, rdy, fd;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   osc_startup_seq u0 (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .en_i          (en),
      .startup_sel_i (sel),
      .on_demand_i   (od),
      .clk_req_i     (req),
      .osc_run_o     (run),
      .clk_ready_o   (rdy),
      .fd_allow_o    (fd)
   );

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // Counts samples where run is high and ready still low, until ready appears
   task automatic wait_ready(output int n);
      n = 0;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (rdy) break;
         if (run) n++;
      end
   endtask

   task automatic start_run(input logic [3:0] s, input logic o);
      @(negedge clk);
      en = 1'b0; sel = s; od = o;
      @(negedge clk);
      en = 1'b1;
   endtask

   task automatic stop_run(input string rq);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk({rq, " run off"}, run, 0);
      chk({rq, " ready off with run (R5)"}, rdy, 0);
      chk({rq, " fd off with run (R8)"}, fd, 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 run in reset", run, 0);
      chk("R1 ready in reset", rdy, 0);
      chk("R1 fd in reset", fd, 0);
   endtask

   task automatic t_default();
      int n;
      en = 1'b1; sel = 4'd0;   // select input ignored: enable already high
      @(negedge clk);
      rst_n = 1'b1;
      wait_ready(n);
      chk("R10 default wait 8192", n, 8192);
      chk("R8 fd low at ready", fd, 0);
      @(negedge clk);
      chk("R8 fd one edge after ready", fd, 1);
      stop_run("R2");
   endtask

   task automatic t_sweep();
      int n;
      int s_list[5] = '{0, 1, 3, 5, 8};
      foreach (s_list[k]) begin
         req = 1'b0;
         start_run(4'(s_list[k]), 1'b0);
         wait_ready(n);
         chk($sformatf("R4 wait sel=%0d", s_list[k]), n, 1 << s_list[k]);
         chk("R2 runs without request", run, 1);
         stop_run("R2");
      end
   endtask

   task automatic t_saturate();
      int n;
      int drops = 0;
      start_run(4'd2, 1'b0);
      wait_ready(n);
      chk("R4 wait sel=2", n, 4);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!rdy || !fd) drops++;
      end
      chk("R9 ready held after terminal", drops, 0);
      stop_run("R9");
   endtask

   task automatic t_max();
      int n;
      start_run(4'hF, 1'b0);
      wait_ready(n);
      chk("R4 wait sel=15", n, 32768);
      stop_run("R4");
   endtask

   task automatic t_demand();
      int n;
      req = 1'b0;
      start_run(4'd3, 1'b1);
      repeat (5) @(negedge clk);
      chk("R3 no request keeps run low", run, 0);
      req = 1'b1;
      wait_ready(n);
      chk("R3 request run wait", n, 8);
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      chk("R3 run drops with request", run, 0);
      chk("R5 ready drops with run", rdy, 0);
      chk("R8 fd drops with run", fd, 0);
      req = 1'b1;
      wait_ready(n);
      chk("R6 full wait after reissue", n, 8);
      // interrupted run: partial count must not carry over
      req = 1'b0;
      @(negedge clk);
      req = 1'b1;
      repeat (3) @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      req = 1'b1;
      wait_ready(n);
      chk("R6 restart after cut-short run", n, 8);
      req = 1'b0;
      stop_run("R3");
   endtask

   task automatic t_frozen();
      int n;
      req = 1'b0;
      @(negedge clk);
      en = 1'b0; sel = 4'd2; od = 1'b0;
      @(negedge clk);
      en = 1'b1; sel = 4'd6; od = 1'b1;   // changed while enable is high
      wait_ready(n);
      chk("R7 select frozen while enabled", n, 4);
      chk("R7 mode frozen while enabled", run, 1);
      stop_run("R7");
      // now disabled for a cycle, so the new values take effect
      en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 new mode latched when disabled", run, 0);
      req = 1'b1;
      wait_ready(n);
      chk("R7 new select latched when disabled", n, 64);
      req = 1'b0;
      stop_run("R7");
   endtask

   initial begin
      t_reset();
      t_default();
      t_sweep();
      t_saturate();
      t_max();
      t_demand();
      t_frozen();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule